// File: doc/BRIEF.md
# Ethernet Controller Command and Status Register Interface

This block is the register front end of a shared-memory Ethernet controller. The host sees two 16-bit ports. One is a select port (`host_addr` = 1) that holds a register index. The other is a data port (`host_addr` = 0) that reads or writes the register that index names. Through these ports the host reaches the following registers:

| Index | Register |
|---|---|
| 0 | command/status word |
| 1, 2 | initialization-block address |
| 3 | bus-mode register |
| 8 to 11 | 64-bit multicast filter |
| 15 | mode word |

The command/status word mixes three kinds of bit. Command bits can only be set. Event flags are sticky and clear when 1 is written to them. State bits are read-only.

Command writes turn into one-cycle strobes toward the datapath engines. Completion and error pulses from those engines are collected into sticky flags. An interrupt request is formed from the flags and an enable bit. The engines and the fetch of the initialization block live outside this block. It sees them only as pulse inputs and drives them only through strobes, a run enable and configuration outputs.

Top module: `mac_csr_if`

## Requirements
- R1: After reset the command/status word reads 0x0004 (halted, bit 2), the select index reads 0, `irq` is 0, all strobes are 0 and the bus mode is 0.
- R2: A command/status write whose bit 2 is 0 behaves as follows. A 1 in bit 0 (init), bit 1 (start) or bit 3 (transmit demand) each raises its strobe for exactly the one cycle after the write. Start also sets bit 1, sets the transmitter-on bit 4 and the receiver-on bit 5, and drives `eng_enable`. Init or start clears the halted bit 2. A 0 written to a command bit changes nothing.
- R3: Bits 0 and 3 of the command/status word always read 0. Writing 0x0005 (init together with halt) reads back as 0x0004 and raises no init strobe.
- R4: The event pulses set sticky flags, but only while the halted bit is 0:
  - `ev_init_done` sets bit 8.
  - `ev_tx_done` sets bit 9.
  - `ev_rx_done` sets bit 10.
  - `ev_mem_err` sets bit 11.
  - `ev_missed` sets bit 12.
  - `ev_carrier_err` sets bit 13.
  - `ev_babble` sets bit 14.

  Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. An event in the same cycle as its clear keeps the flag set.
- R5: Writing 1 to bit 2 does all of the following:
  - sets the halted bit;
  - clears start, transmitter-on, receiver-on, interrupt enable (bit 6) and every event flag;
  - clears the byte-swap bit 2 of the bus-mode register;
  - suppresses any init, start or demand strobe of the same write.
- R6: Bit 15 reads as the OR of bits 11, 12, 13 and 14. Bit 7 reads as the OR of bits 8, 9, 10, 11, 12 and 14; bit 13 does not take part in bit 7.
- R7: `irq` equals bit 7 AND bit 6. Every command/status write without bit 2 loads bit 6 from the written data.
- R8: A write to the select port stores a 4-bit index, which reads back in the low bits of the select port. The index stays unchanged across any number of data-port accesses.
- R9: The following registers accept writes only while the halted bit is 1; at other times writes to them are ignored:
  - index 1: 16 bits;
  - index 2: low 8 bits, upper bits read 0;
  - index 3: low 3 bits, where bit 0 is byte control, bit 1 is address-latch control and bit 2 is byte swap (1 = big-endian).

  `init_addr` is {index 2 [7:0], index 1}.
- R10: Indexes 8 to 11 form `mcast_filter`, with index 8 as the least significant word. Index 15 is a 16-bit mode word whose bit 15 drives `promisc`. These registers are always writable. Unmapped indexes read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the addressed port |
| host_addr | input | 1 | 0 = data port, 1 = select port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the addressed port (combinational) |
| ev_init_done | input | 1 | Initialization block fetched |
| ev_tx_done | input | 1 | Frame transmitted |
| ev_rx_done | input | 1 | Frame received |
| ev_mem_err | input | 1 | Memory access error |
| ev_missed | input | 1 | Received frame dropped |
| ev_carrier_err | input | 1 | Carrier or heartbeat error |
| ev_babble | input | 1 | Transmit overlength |
| strobe_init | output | 1 | One-cycle request to fetch the initialization block |
| strobe_start | output | 1 | One-cycle request to start the engines |
| strobe_tx_demand | output | 1 | One-cycle transmit poll request |
| eng_enable | output | 1 | Transmit and receive engines running |
| irq | output | 1 | Interrupt request, active high |
| init_addr | output | 24 | Initialization-block address |
| bus_mode | output | 3 | Byte control, address-latch control, byte swap |
| mcast_filter | output | 64 | Multicast hash filter |
| promisc | output | 1 | Promiscuous receive mode |

## Verification
The embedded properties check five behaviours on every cycle:
- a start strobe always coincides with running and not halted;
- a halt write leaves the engines off, the enable clear, the flags empty and byte swap dropped;
- no flag rises without its event pulse;
- the select index and the locked address registers hold their values;
- the init bit never appears in the readback.

The exact composition of the command/status word needs the bench's scenarios. This covers the summary and interrupt bits, the priority of an event over a same-cycle clear, and the ignoring of events while halted. The bench checks it against a reference model under random command and event traffic, along with directed cases such as init together with halt and writes to locked or unmapped registers.

// File: rtl/mac_csr_pkg.sv
// Package: shared widths, register indexes and command/status bit positions
// for the controller register interface. Assumes a 16-bit host data path.
package mac_csr_pkg;
    localparam int DATA_W   = 16;
    localparam int IDX_W    = 4;
    localparam int NUM_EV   = 7;   // sticky event flags, bits 8..14
    localparam int NUM_FILT = 4;   // 16-bit words of the multicast filter
    localparam int HI_W     = 8;   // used width of the upper address word
    localparam int BUS_W    = 3;   // bus-mode bits

    // register indexes (host software depends on them)
    localparam logic [IDX_W-1:0] IDX_CMD   = 4'd0;
    localparam logic [IDX_W-1:0] IDX_IB_LO = 4'd1;
    localparam logic [IDX_W-1:0] IDX_IB_HI = 4'd2;
    localparam logic [IDX_W-1:0] IDX_BUS   = 4'd3;
    localparam logic [IDX_W-1:0] IDX_FILT0 = 4'd8;
    localparam logic [IDX_W-1:0] IDX_MODE  = 4'd15;

    // command/status bit positions
    localparam int B_INIT  = 0;
    localparam int B_STRT  = 1;
    localparam int B_HALT  = 2;
    localparam int B_TDMD  = 3;
    localparam int B_TXON  = 4;
    localparam int B_RXON  = 5;
    localparam int B_IEN   = 6;
    localparam int B_INTR  = 7;
    localparam int B_EV0   = 8;
    localparam int B_ERR   = 15;

    // event flag order inside the flag vector
    localparam int EV_IDON = 0;
    localparam int EV_TINT = 1;
    localparam int EV_RINT = 2;
    localparam int EV_MERR = 3;
    localparam int EV_MISS = 4;
    localparam int EV_CERR = 5;
    localparam int EV_BABL = 6;

    localparam int BUS_SWAP = 2;
endpackage

// File: rtl/csr_cmd_ctl.sv
// Module: command decoder. Holds the halted, started, running and interrupt
// enable state and turns command writes into one-cycle strobes.
// Assumes cmd_wr is a single-cycle write of the command/status word; a halt
// bit in the write overrides every other command in the same write.
module csr_cmd_ctl
    import mac_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [B_IEN:0]   cmd_bits,
    output logic             halt_wr,
    output logic             halted,
    output logic             started,
    output logic             running,
    output logic             ien,
    output logic             stb_init,
    output logic             stb_start,
    output logic             stb_tdmd
);
    logic go_wr;

    // Split a command write into a halt request and an ordinary command.
    always_comb begin
        halt_wr = cmd_wr &  cmd_bits[B_HALT];
        go_wr   = cmd_wr & ~cmd_bits[B_HALT];
    end

    // Registered strobes, high for the single cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_init  <= 1'b0;
            stb_start <= 1'b0;
            stb_tdmd  <= 1'b0;
        end else begin
            stb_init  <= go_wr & cmd_bits[B_INIT];
            stb_start <= go_wr & cmd_bits[B_STRT];
            stb_tdmd  <= go_wr & cmd_bits[B_TDMD];
        end
    end

    // Controller state: halt wins, start and init leave the halted state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted  <= 1'b1;
            started <= 1'b0;
            running <= 1'b0;
            ien     <= 1'b0;
        end else if (halt_wr) begin
            halted  <= 1'b1;
            started <= 1'b0;
            running <= 1'b0;
            ien     <= 1'b0;
        end else if (go_wr) begin
            ien <= cmd_bits[B_IEN];
            if (cmd_bits[B_STRT]) begin
                started <= 1'b1;
                running <= 1'b1;
            end
            if (cmd_bits[B_STRT] || cmd_bits[B_INIT])
                halted <= 1'b0;
        end
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        stb_start |-> (running && started && !halted)); // R2
    AST_HALT_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wr |=> (halted && !running && !ien && !stb_init && !stb_start && !stb_tdmd)); // R5
endmodule

// File: rtl/csr_event_flags.sv
// Module: sticky event flags. Each flag is set by its event pulse while the
// controller is not halted and is cleared by a write of 1 to its bit or by a
// halt write. Assumes event pulses are synchronous to clk.
module csr_event_flags
    import mac_csr_pkg::*;
#(
    parameter int N = NUM_EV
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_en,
    input  logic         clear_all,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] ev_in,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag: halt clears, a new event beats a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (clear_all)
                flags[i] <= 1'b0;
            else if (capture_en && ev_in[i])
                flags[i] <= 1'b1;
            else if (clr_wr && clr_bits[i])
                flags[i] <= 1'b0;
        end

        AST_FLAG_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> ($past(ev_in[i]) && $past(capture_en))); // R4
    end

    AST_HALT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (flags == '0)); // R5
endmodule

// File: rtl/csr_cfg_regs.sv
// Module: configuration registers: initialization address words, bus mode,
// multicast filter words and the mode word. Address and bus-mode registers
// accept writes only while the controller is halted; a halt write drops
// the byte-swap bit. Assumes wr_en is a data-port write to index idx.
module csr_cfg_regs
    import mac_csr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               idx,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           halted,
    input  logic                           swap_clr,
    output logic [DATA_W-1:0]              ib_lo,
    output logic [HI_W-1:0]                ib_hi,
    output logic [BUS_W-1:0]               bus_mode,
    output logic [NUM_FILT-1:0][DATA_W-1:0] filt,
    output logic [DATA_W-1:0]              mode_word
);
    logic lock_ok;

    // Locked registers are writable only while halted.
    always_comb lock_ok = wr_en & halted;

    // Initialization-block address words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ib_lo <= '0;
            ib_hi <= '0;
        end else if (lock_ok) begin
            if (idx == IDX_IB_LO) ib_lo <= wdata;
            if (idx == IDX_IB_HI) ib_hi <= wdata[HI_W-1:0];
        end
    end

    // Bus mode; a halt write returns the byte order to little-endian.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_mode <= '0;
        else if (swap_clr)
            bus_mode[BUS_SWAP] <= 1'b0;
        else if (lock_ok && idx == IDX_BUS)
            bus_mode <= wdata[BUS_W-1:0];
    end

    for (genvar w = 0; w < NUM_FILT; w++) begin : g_filt
        // One 16-bit word of the multicast filter, always writable.
        always_ff @(posedge clk) begin
            if (!rst_n)
                filt[w] <= '0;
            else if (wr_en && idx == IDX_FILT0 + IDX_W'(w))
                filt[w] <= wdata;
        end
    end

    // Mode word, always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_word <= '0;
        else if (wr_en && idx == IDX_MODE)
            mode_word <= wdata;
    end

    AST_SWAP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        swap_clr |=> !bus_mode[BUS_SWAP]); // R5
    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> ($stable(ib_lo) && $stable(ib_hi) && $stable(bus_mode[1:0]))); // R9
endmodule

// File: rtl/mac_csr_if.sv
// Module: top of the register interface. Holds the select index, routes
// data-port writes to the command decoder, event flags and configuration
// registers, and assembles the read data and the interrupt request.
// Assumes one host access per cycle and a combinational read path.
module mac_csr_if
    import mac_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        ev_init_done,
    input  logic        ev_tx_done,
    input  logic        ev_rx_done,
    input  logic        ev_mem_err,
    input  logic        ev_missed,
    input  logic        ev_carrier_err,
    input  logic        ev_babble,
    output logic        strobe_init,
    output logic        strobe_start,
    output logic        strobe_tx_demand,
    output logic        eng_enable,
    output logic        irq,
    output logic [23:0] init_addr,
    output logic [2:0]  bus_mode,
    output logic [63:0] mcast_filter,
    output logic        promisc
);
    logic [IDX_W-1:0]                sel_q;
    logic                            sel_wr, data_wr, cmd_wr;
    logic                            halt_wr, halted, started, running, ien;
    logic [NUM_EV-1:0]               ev_vec, flags;
    logic                            sum_err, sum_intr;
    logic [DATA_W-1:0]               ib_lo, mode_word, cmd_word;
    logic [HI_W-1:0]                 ib_hi;
    logic [NUM_FILT-1:0][DATA_W-1:0] filt;

    // Decode the host access into select, data and command writes.
    always_comb begin
        sel_wr  = host_wr &  host_addr;
        data_wr = host_wr & ~host_addr;
        cmd_wr  = data_wr & (sel_q == IDX_CMD);
    end

    // Register-select port; survives any number of data accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_wr)
            sel_q <= host_wdata[IDX_W-1:0];
    end

    // Gather the event inputs in flag order.
    always_comb begin
        ev_vec[EV_IDON] = ev_init_done;
        ev_vec[EV_TINT] = ev_tx_done;
        ev_vec[EV_RINT] = ev_rx_done;
        ev_vec[EV_MERR] = ev_mem_err;
        ev_vec[EV_MISS] = ev_missed;
        ev_vec[EV_CERR] = ev_carrier_err;
        ev_vec[EV_BABL] = ev_babble;
    end

    csr_cmd_ctl u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_bits  (host_wdata[B_IEN:0]),
        .halt_wr   (halt_wr),
        .halted    (halted),
        .started   (started),
        .running   (running),
        .ien       (ien),
        .stb_init  (strobe_init),
        .stb_start (strobe_start),
        .stb_tdmd  (strobe_tx_demand)
    );

    csr_event_flags #(.N(NUM_EV)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (~halted),
        .clear_all  (halt_wr),
        .clr_wr     (cmd_wr),
        .clr_bits   (host_wdata[B_EV0 +: NUM_EV]),
        .ev_in      (ev_vec),
        .flags      (flags)
    );

    csr_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .idx       (sel_q),
        .wdata     (host_wdata),
        .halted    (halted),
        .swap_clr  (halt_wr),
        .ib_lo     (ib_lo),
        .ib_hi     (ib_hi),
        .bus_mode  (bus_mode),
        .filt      (filt),
        .mode_word (mode_word)
    );

    // Summary bits, command/status word and interrupt request.
    always_comb begin
        sum_err  = flags[EV_BABL] | flags[EV_CERR] | flags[EV_MISS] | flags[EV_MERR];
        sum_intr = flags[EV_BABL] | flags[EV_MISS] | flags[EV_MERR] |
                   flags[EV_RINT] | flags[EV_TINT] | flags[EV_IDON];
        cmd_word                      = '0;
        cmd_word[B_STRT]              = started;
        cmd_word[B_HALT]              = halted;
        cmd_word[B_TXON]              = running;
        cmd_word[B_RXON]              = running;
        cmd_word[B_IEN]               = ien;
        cmd_word[B_INTR]              = sum_intr;
        cmd_word[B_EV0 +: NUM_EV]     = flags;
        cmd_word[B_ERR]               = sum_err;
        irq                           = sum_intr & ien;
    end

    // Read multiplexer for both host ports.
    always_comb begin
        host_rdata = '0;
        if (host_addr)
            host_rdata[IDX_W-1:0] = sel_q;
        else begin
            case (sel_q)
                IDX_CMD:           host_rdata = cmd_word;
                IDX_IB_LO:         host_rdata = ib_lo;
                IDX_IB_HI:         host_rdata[HI_W-1:0] = ib_hi;
                IDX_BUS:           host_rdata[BUS_W-1:0] = bus_mode;
                IDX_FILT0:         host_rdata = filt[0];
                IDX_FILT0 + 4'd1:  host_rdata = filt[1];
                IDX_FILT0 + 4'd2:  host_rdata = filt[2];
                IDX_FILT0 + 4'd3:  host_rdata = filt[3];
                IDX_MODE:          host_rdata = mode_word;
                default:           host_rdata = '0;
            endcase
        end
    end

    // Configuration outputs toward the datapath.
    always_comb begin
        eng_enable   = running;
        init_addr    = {ib_hi, ib_lo};
        mcast_filter = filt;
        promisc      = mode_word[DATA_W-1];
    end

    AST_INIT_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_addr && sel_q == IDX_CMD) |-> !host_rdata[B_INIT] && !host_rdata[B_TDMD]); // R3
    AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(sel_q)); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien && (flags & 7'b1011111) != '0)); // R7
endmodule

// File: tb/mac_csr_if_tb_top.sv
module mac_csr_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_addr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [6:0]  ev = '0;
    logic        strobe_init, strobe_start, strobe_tx_demand, eng_enable, irq, promisc;
    logic [23:0] init_addr;
    logic [2:0]  bus_mode;
    logic [63:0] mcast_filter;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model of the command/status state
    bit       m_halt, m_strt, m_run, m_ien;
    bit [6:0] m_ev;

    always #2 clk = ~clk;

    mac_csr_if dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_init_done(ev[0]), .ev_tx_done(ev[1]), .ev_rx_done(ev[2]),
        .ev_mem_err(ev[3]), .ev_missed(ev[4]), .ev_carrier_err(ev[5]),
        .ev_babble(ev[6]),
        .strobe_init(strobe_init), .strobe_start(strobe_start),
        .strobe_tx_demand(strobe_tx_demand), .eng_enable(eng_enable), .irq(irq),
        .init_addr(init_addr), .bus_mode(bus_mode), .mcast_filter(mcast_filter),
        .promisc(promisc)
    );

    function automatic logic [15:0] exp_word();
        logic [15:0] w = '0;
        w[1]    = m_strt;
        w[2]    = m_halt;
        w[4]    = m_run;
        w[5]    = m_run;
        w[6]    = m_ien;
        w[14:8] = m_ev;
        w[7]    = m_ev[0] | m_ev[1] | m_ev[2] | m_ev[3] | m_ev[4] | m_ev[6];
        w[15]   = m_ev[3] | m_ev[4] | m_ev[5] | m_ev[6];
        return w;
    endfunction

    function automatic bit exp_irq();
        logic [15:0] w = exp_word();
        return w[7] & w[6];
    endfunction

    // apply one cycle of host write (w,d) and events e to the model
    function automatic void model_step(bit w, logic [15:0] d, logic [6:0] e);
        bit old_halt = m_halt;
        bit hw = w & d[2];
        for (int i = 0; i < 7; i++) begin
            if (hw) m_ev[i] = 1'b0;
            else if (!old_halt && e[i]) m_ev[i] = 1'b1;
            else if (w && d[8+i]) m_ev[i] = 1'b0;
        end
        if (hw) begin
            m_halt = 1'b1; m_strt = 1'b0; m_run = 1'b0; m_ien = 1'b0;
        end else if (w) begin
            m_ien = d[6];
            if (d[1]) begin m_strt = 1'b1; m_run = 1'b1; m_halt = 1'b0; end
            if (d[0]) m_halt = 1'b0;
        end
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(bit a, logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 1'b0;
        #1;
    endtask

    task automatic cmd(logic [15:0] d);
        wr(1'b0, d);
        model_step(1'b1, d, 7'd0);
    endtask

    task automatic rd(logic [3:0] idx, output logic [15:0] v);
        wr(1'b1, {12'd0, idx});
        host_addr = 1'b0; #1;
        v = host_rdata;
    endtask

    task automatic pulse(logic [6:0] e);
        @(negedge clk);
        ev = e;
        @(negedge clk);
        ev = '0;
        model_step(1'b0, 16'd0, e);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4711));
        m_halt = 1'b1; m_strt = 1'b0; m_run = 1'b0; m_ien = 1'b0; m_ev = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 word", host_rdata, 16'h0004);
        chk("R1 irq", irq, 0);
        chk("R1 strobes", {strobe_init, strobe_start, strobe_tx_demand}, 0);
        chk("R1 bus", bus_mode, 0);
        host_addr = 1'b1; #1;
        chk("R1 sel", host_rdata, 0);
        host_addr = 1'b0;

        // R9 locked registers writable while halted
        wr(1'b1, 16'd3); wr(1'b0, 16'hFFFF); rd(4'd3, v); chk("R9 bus", v, 16'h0007);
        wr(1'b1, 16'd1); wr(1'b0, 16'hBEEF);
        wr(1'b1, 16'd2); wr(1'b0, 16'hA512); rd(4'd2, v); chk("R9 hi", v, 16'h0012);
        chk("R9 addr", init_addr, 24'h12BEEF);

        // R10 filter, mode word, unmapped index
        for (int k = 0; k < 4; k++) begin
            wr(1'b1, 16'(8 + k)); wr(1'b0, 16'h1111 * 16'(k + 1));
        end
        chk("R10 filter", mcast_filter, 64'h4444_3333_2222_1111);
        wr(1'b1, 16'd15); wr(1'b0, 16'h8001); rd(4'd15, v);
        chk("R10 mode", v, 16'h8001);
        chk("R10 promisc", promisc, 1);
        wr(1'b1, 16'd5); wr(1'b0, 16'hFFFF); rd(4'd5, v);
        chk("R10 unmapped", v, 0);

        // R3 R5 init together with halt
        wr(1'b1, 16'd0);
        cmd(16'h0005);
        chk("R3 init+halt strobe", strobe_init, 0);
        chk("R3 init+halt word", host_rdata, 16'h0004);
        chk("R5 swap dropped", bus_mode, 3'b011);

        // R2 init strobe one cycle
        cmd(16'h0001);
        chk("R2 init strobe", strobe_init, 1);
        @(negedge clk); #1;
        chk("R2 init strobe end", strobe_init, 0);
        chk("R3 init hidden", host_rdata, exp_word());

        // R9 locked while running; R8 index persists
        wr(1'b1, 16'd1); wr(1'b0, 16'h1111); rd(4'd1, v);
        chk("R9 locked", v, 16'hBEEF);
        wr(1'b1, 16'd0);
        wr(1'b0, 16'h0000); wr(1'b0, 16'h0000);
        model_step(1'b1, 16'h0000, 7'd0); model_step(1'b1, 16'h0000, 7'd0);
        host_addr = 1'b1; #1;
        chk("R8 sel kept", host_rdata, 0);
        host_addr = 1'b0; #1;

        // R4 R6 init done sets flag and summary
        pulse(7'b0000001);
        chk("R4 idon", host_rdata, 16'h0180);
        chk("R7 irq off", irq, 0);
        cmd(16'h0040);
        chk("R7 irq on", irq, 1);
        cmd(16'h0042);
        chk("R2 start strobe", strobe_start, 1);
        chk("R2 start word", host_rdata, 16'h01F2);
        chk("R2 engines", eng_enable, 1);
        cmd(16'h0048);
        chk("R2 demand strobe", strobe_tx_demand, 1);
        chk("R3 demand hidden", host_rdata, 16'h01F2);

        // R6 carrier error: summary error but no interrupt
        pulse(7'b0100000);
        cmd(16'h0140);
        chk("R6 cerr word", host_rdata, 16'hA072);
        chk("R6 cerr no irq", irq, 0);

        // R4 event and clear in the same cycle: event wins
        @(negedge clk);
        host_wdata = 16'h2040; host_wr = 1'b1; ev = 7'b0100000;
        @(negedge clk);
        host_wr = 1'b0; ev = '0;
        model_step(1'b1, 16'h2040, 7'b0100000);
        #1;
        chk("R4 set beats clear", host_rdata[13], 1);

        // R5 halt clears; R4 events ignored while halted
        cmd(16'h0004);
        chk("R5 halt word", host_rdata, 16'h0004);
        pulse(7'b0000100);
        chk("R4 ignored halted", host_rdata, 16'h0004);
        chk("R5 halted irq", irq, 0);

        // random traffic against the model (R2 R4 R5 R6 R7)
        for (int n = 0; n < 400; n++) begin
            bit w = ($urandom % 2) == 1;
            logic [15:0] d = 16'($urandom);
            logic [6:0] e = (($urandom % 3) == 0) ? 7'($urandom) : 7'd0;
            bit go;
            if (($urandom % 10) != 0) d[2] = 1'b0;
            go = w & ~d[2];
            @(negedge clk);
            host_addr = 1'b0; host_wdata = d; host_wr = w; ev = e;
            @(negedge clk);
            host_wr = 1'b0; ev = '0;
            model_step(w, d, e);
            #1;
            chk("R4 R6 random word", host_rdata, exp_word());
            chk("R7 random irq", irq, exp_irq());
            chk("R2 random strobes", {strobe_init, strobe_start, strobe_tx_demand},
                {go & d[0], go & d[1], go & d[3]});
        end
        finish_run();
    end
endmodule